// File: doc/BRIEF.md
# Bus Access Watchpoint Comparator

This block watches the accesses of a CPU bus with a 16-bit address and a 16-bit data bus. It produces a one-cycle match pulse when an access meets a set of programmed conditions. The conditions are:

- an exact address;
- an optional read/write direction;
- an optional access size, byte or word;
- an optional data comparison, masked bit by bit, across the two byte lanes.

The upper data lane always carries the byte at the access address. On a word access, the lower lane carries the byte one address higher.

Software sets up the block through a small write port with four registers, chosen by `cfgSel`:

| `cfgSel` | Register |
|---|---|
| 0 | compare address |
| 1 | control |
| 2 | data value |
| 3 | data mask |

The control register has these bits:

| Bit | Meaning |
|---|---|
| 0 | global enable |
| 1 | direction check on |
| 2 | direction wanted is read |
| 3 | size check on |
| 4 | size wanted is byte |

The address, value and mask registers can only be written while the block is disabled. The control register can be written at any time, so that the block can always be switched off.

Top module: `bus_watch_cmp`

## Requirements
- R1: After reset every register is zero, so the block is disabled, the mask is clear and `matchPulse` is 0, whatever access occurs.
- R2: An access matches only when `busAddr` equals the compare address exactly. A word access at the compare address minus one does not match, although it covers that address.
- R3: With size check off (control bit 3 = 0), byte accesses (`busByte`=1) and word accesses (`busByte`=0) to the compare address both match.
- R4: With size check on, an access matches only if `busByte` equals control bit 4. For example, with byte programmed, a word access at the same address does not match.
- R5: With direction check on (control bit 1 = 1), an access matches only if `busRd` (1 = read) equals control bit 2. With the check off, direction is ignored.
- R6: The data check passes when, for every bit set in the mask, `busData` equals the data value in that bit. Masked-out bits always pass, and a zero mask disables the data check.
- R7: Data bits [15:8] correspond to the byte at the compare address and bits [7:0] to the byte at the address plus one:
  - mask 0xFF00 checks only the addressed byte;
  - mask 0x00FF checks only the next byte;
  - mask 0xFFFF checks both bytes.
- R8: On a byte access with size check off, the low-lane mask bits still compare whatever the bus carries on bits [7:0]. This can give a match the user did not intend, and the block keeps that behaviour.
- R9: `matchPulse` is 1 for exactly one clock, in the cycle after a `busValid` cycle whose access meets every enabled condition. It is 0 when the enable bit is clear or `busValid` is 0.
- R10: Writes to the address, value or mask registers are ignored while the enable bit is set. Writes to the control register always take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, synchronous |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Register select: 0 address, 1 control, 2 value, 3 mask |
| cfgData | input | 16 | Configuration write data |
| busValid | input | 1 | Bus access valid this cycle |
| busAddr | input | 16 | Access address |
| busRd | input | 1 | 1 = read, 0 = write |
| busByte | input | 1 | 1 = byte access, 0 = word access |
| busData | input | 16 | Data bus; [15:8] is the addressed byte |
| matchPulse | output | 1 | Registered one-cycle match pulse |

## Verification
The bench sweeps every combination of the four qualifier bits, several masks, both directions, both sizes, addresses one below, at and one above the target, and data that differs in either lane.

Each sweep catches a particular kind of fault:
- A design that matched on address overlap, rather than exact equality, would fire on the word access one byte below the target.
- A design with the lanes swapped would fail the 0xFF00 and 0x00FF mask cases.
- A design that suppressed the low lane on byte accesses would miss the deliberate unintended match, which the bench drives with chosen low-lane values.

Separate directed tests check three further points: that an address write while enabled is lost, that the pulse lasts one cycle, and that the enable bit gates the output.

// File: rtl/bus_watch_pkg.sv
package bus_watch_pkg;

  // Register select codes
  localparam logic [1:0] SEL_ADDR  = 2'd0;
  localparam logic [1:0] SEL_CTL   = 2'd1;
  localparam logic [1:0] SEL_VALUE = 2'd2;
  localparam logic [1:0] SEL_MASK  = 2'd3;

  localparam int CTL_W = 5;

  // Control register; the first member is the most significant bit
  typedef struct packed {
    logic sizeByte;  // bit 4
    logic sizeEn;    // bit 3
    logic dirRead;   // bit 2
    logic dirEn;     // bit 1
    logic enable;    // bit 0
  } ctlReg_t;

  // Write strobes from the control to the datapath
  typedef struct packed {
    logic wrAddr;
    logic wrCtl;
    logic wrValue;
    logic wrMask;
  } cfgStrobe_t;

endpackage

// File: rtl/bus_watch_ctrl.sv
module bus_watch_ctrl
  import bus_watch_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWe,
  input  logic [1:0] cfgSel,
  input  logic       ctlEnable,
  output cfgStrobe_t strobe
);

  logic unlocked;

  // The control register is always writable; the rest only while disabled.
  assign unlocked = ~ctlEnable;

  always_comb begin
    strobe         = '0;
    strobe.wrCtl   = cfgWe && (cfgSel == SEL_CTL);
    strobe.wrAddr  = cfgWe && unlocked && (cfgSel == SEL_ADDR);
    strobe.wrValue = cfgWe && unlocked && (cfgSel == SEL_VALUE);
    strobe.wrMask  = cfgWe && unlocked && (cfgSel == SEL_MASK);
  end

  // R10: at most one register is written per cycle
  a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));

endmodule

// File: rtl/bus_watch_dp.sv
module bus_watch_dp
  import bus_watch_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        strobe,
  input  logic [DATA_W-1:0] cfgData,
  input  logic              busValid,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busByte,
  input  logic [DATA_W-1:0] busData,
  output logic              ctlEnable,
  output logic              matchPulse
);

  localparam int LANES = DATA_W / LANE_W;

  logic [ADDR_W-1:0] addrReg;
  ctlReg_t           ctlReg;
  logic [DATA_W-1:0] valueReg;
  logic [DATA_W-1:0] maskReg;
  logic [LANES-1:0]  laneOk;
  logic addrOk, dirOk, sizeOk, dataOk, hit;

  // Configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg  <= '0;
      ctlReg   <= '0;
      valueReg <= '0;
      maskReg  <= '0;
    end else begin
      if (strobe.wrAddr)  addrReg  <= cfgData[ADDR_W-1:0];
      if (strobe.wrCtl)   ctlReg   <= ctlReg_t'(cfgData[CTL_W-1:0]);
      if (strobe.wrValue) valueReg <= cfgData;
      if (strobe.wrMask)  maskReg  <= cfgData;
    end
  end

  assign ctlEnable = ctlReg.enable;

  // Lane 0 is the most significant lane and holds the byte at the access address.
  // Lanes are compared whatever the access size.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int HI = DATA_W - 1 - i * LANE_W;
    assign laneOk[i] = ~|((busData[HI -: LANE_W] ^ valueReg[HI -: LANE_W])
                          & maskReg[HI -: LANE_W]);
  end

  assign addrOk = (busAddr == addrReg);
  assign dirOk  = ~ctlReg.dirEn  | (busRd   == ctlReg.dirRead);
  assign sizeOk = ~ctlReg.sizeEn | (busByte == ctlReg.sizeByte);
  assign dataOk = &laneOk;
  assign hit    = ctlReg.enable & busValid & addrOk & dirOk & sizeOk & dataOk;

  always_ff @(posedge clk) begin
    if (!rstN) matchPulse <= 1'b0;
    else       matchPulse <= hit;
  end

  // R9: a pulse always follows a valid bus cycle
  a_r9_follows_strobe: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |-> $past(busValid));

  // R9: a disabled comparator gives no pulse in the next cycle
  a_r9_enable_gates: assert property (@(posedge clk) disable iff (!rstN)
    !ctlEnable |=> !matchPulse);

  // R2: a pulse is only caused by an exact address match
  a_r2_exact_addr: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |-> $past(busAddr) == addrReg);

  // R4: with the size check on, the matched access had the programmed size
  a_r4_size_qualified: assert property (@(posedge clk) disable iff (!rstN)
    (matchPulse && $past(ctlReg.sizeEn)) |-> $past(busByte) == $past(ctlReg.sizeByte));

  // R10: address, value and mask stay put while the comparator is enabled
  a_r10_locked: assert property (@(posedge clk) disable iff (!rstN)
    ctlEnable |=> ($stable(addrReg) && $stable(valueReg) && $stable(maskReg)));

endmodule

// File: rtl/bus_watch_cmp.sv
module bus_watch_cmp
  import bus_watch_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [DATA_W-1:0] cfgData,
  input  logic              busValid,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busByte,
  input  logic [DATA_W-1:0] busData,
  output logic              matchPulse
);

  cfgStrobe_t strobe;
  logic       ctlEnable;

  bus_watch_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWe     (cfgWe),
    .cfgSel    (cfgSel),
    .ctlEnable (ctlEnable),
    .strobe    (strobe)
  );

  bus_watch_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LANE_W (LANE_W)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cfgData    (cfgData),
    .busValid   (busValid),
    .busAddr    (busAddr),
    .busRd      (busRd),
    .busByte    (busByte),
    .busData    (busData),
    .ctlEnable  (ctlEnable),
    .matchPulse (matchPulse)
  );

endmodule

// File: tb/test_bus_watch_cmp.sv
`timescale 1ns/1ps
module test_bus_watch_cmp;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgSel = '0;
  logic [15:0] cfgData = '0;
  logic        busValid = 1'b0;
  logic [15:0] busAddr = '0;
  logic        busRd = 1'b0;
  logic        busByte = 1'b0;
  logic [15:0] busData = '0;
  logic        matchPulse;

  int nTests = 0;
  int nFails = 0;

  always #4 clk = ~clk;  // 125 MHz

  bus_watch_cmp i_bus_watch_cmp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .busValid(busValid), .busAddr(busAddr), .busRd(busRd), .busByte(busByte),
    .busData(busData), .matchPulse(matchPulse)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    nTests++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: matchPulse=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wrCfg(input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = sel; cfgData = val;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // Drive one valid cycle, then sample the registered pulse one clock later.
  task automatic access(input logic [15:0] a, input logic rd, input logic byt,
                        input logic [15:0] d, input logic exp, input string tag);
    @(negedge clk);
    busValid = 1'b1; busAddr = a; busRd = rd; busByte = byt; busData = d;
    @(negedge clk);
    busValid = 1'b0;
    check(tag, matchPulse, exp);
  endtask

  // Turn the comparator off, load the registers, then turn it on with the qualifier bits.
  task automatic setup(input logic [15:0] a, input logic [15:0] v,
                       input logic [15:0] m, input logic [3:0] q);
    wrCfg(2'd1, 16'h0000);
    wrCfg(2'd0, a);
    wrCfg(2'd2, v);
    wrCfg(2'd3, m);
    wrCfg(2'd1, {11'd0, q, 1'b1});
  endtask

  localparam logic [15:0] TA = 16'h4A31;
  localparam logic [15:0] TV = 16'hC35A;

  initial begin : watchdog
    #(200000 * 8);
    nFails++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin : main
    logic [15:0] masks [5];
    masks[0] = 16'h0000; masks[1] = 16'hFF00; masks[2] = 16'h00FF;
    masks[3] = 16'hFFFF; masks[4] = 16'h0F0F;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: after reset the block is disabled with a clear mask and address zero
    check("R1 reset", matchPulse, 1'b0);
    access(16'h0000, 1'b1, 1'b0, 16'h0000, 1'b0, "R1 disabled after reset");

    // Sweep over qualifiers, masks, direction, size, address offset and data
    for (int q = 0; q < 16; q++) begin
      for (int mi = 0; mi < 5; mi++) begin
        setup(TA, TV, masks[mi], q[3:0]);
        for (int rd = 0; rd < 2; rd++)
          for (int byt = 0; byt < 2; byt++)
            for (int ao = -1; ao <= 1; ao++)
              for (int ds = 0; ds < 3; ds++) begin
                logic [15:0] a, d;
                logic dirEn, dirRead, sizeEn, sizeByte, exp;
                string tag;
                dirEn = q[0]; dirRead = q[1]; sizeEn = q[2]; sizeByte = q[3];
                a = TA + 16'(ao);
                d = (ds == 0) ? TV : (ds == 1) ? (TV ^ 16'h0100) : (TV ^ 16'h0001);
                exp = (ao == 0)
                      && (!dirEn || (rd[0] == dirRead))
                      && (!sizeEn || (byt[0] == sizeByte))
                      && (((d ^ TV) & masks[mi]) == 16'h0000);
                if (ao != 0)                                tag = "R2 exact address";
                else if (masks[mi] == 16'h0000)             tag = "R6 zero mask";
                else if (ds != 0 && masks[mi] != 16'h0F0F)  tag = "R7 lane mapping";
                else if (ds != 0)                           tag = "R6 per-bit mask";
                else if (sizeEn)                            tag = "R4 size qualified";
                else if (dirEn)                             tag = "R5 direction qualified";
                else                                        tag = "R3 any size";
                access(a, rd[0], byt[0], d, exp, tag);
              end
      end
    end

    // R8: byte access with the size check off, low-lane mask set; bits [7:0] are still compared
    setup(TA, TV, 16'h00FF, 4'b0000);
    access(TA, 1'b1, 1'b1, {8'h11, TV[7:0]}, 1'b1, "R8 unintended low-lane match");
    access(TA, 1'b1, 1'b1, {8'h11, ~TV[7:0]}, 1'b0, "R8 low-lane garbage mismatch");
    setup(TA, TV, 16'hFFFF, 4'b0000);
    access(TA, 1'b0, 1'b1, TV, 1'b1, "R8 full mask byte access");

    // R9: one-cycle pulse; no pulse without busValid
    @(negedge clk);
    busValid = 1'b1; busAddr = TA; busByte = 1'b0; busData = TV;
    @(negedge clk);
    busValid = 1'b0;
    check("R9 pulse present", matchPulse, 1'b1);
    @(negedge clk);
    check("R9 pulse one cycle", matchPulse, 1'b0);
    @(negedge clk);
    busAddr = TA; busData = TV;
    @(negedge clk);
    check("R9 no busValid", matchPulse, 1'b0);
    wrCfg(2'd1, 16'h0000);
    access(TA, 1'b0, 1'b0, TV, 1'b0, "R9 enable clear");

    // R10: an address write while enabled is lost; the control register is still writable
    setup(TA, TV, 16'h0000, 4'b0000);
    wrCfg(2'd0, 16'h1234);
    access(TA, 1'b0, 1'b0, TV, 1'b1, "R10 old address kept");
    access(16'h1234, 1'b0, 1'b0, TV, 1'b0, "R10 locked write ignored");
    wrCfg(2'd3, 16'hFFFF);
    access(TA, 1'b0, 1'b0, 16'h0000, 1'b1, "R10 locked mask ignored");
    wrCfg(2'd1, 16'h0000);
    wrCfg(2'd0, 16'h1234);
    wrCfg(2'd1, 16'h0001);
    access(16'h1234, 1'b0, 1'b0, TV, 1'b1, "R10 write while disabled");

    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

endmodule